// File: doc/BRIEF.md
# Parallel NOR Write-Buffer Programming Sequencer

This block is the host-side engine that programs a run of 16-bit words into an asynchronous parallel NOR flash through the flash's buffered-program command flow. A client raises a one-cycle request carrying a sector address, the first word address and a word count. The words come either from a single fill value held for the whole run or from a stream that the block pulls one word at a time.

An accepted request is carried out in order. The block waits until the flash reports ready. It then writes the two unlock cycles, the load command and the count (sent as count minus one), one address/data pair per word, and the confirm command. Every write is a timed strobe on the chip-enable and write-enable lines. After the confirm the block watches the ready/busy line. It raises a done pulse when the flash becomes ready again. It raises a timeout pulse if the line stays busy too long.

A request with a zero count, a count above the buffer size, or a range that crosses a buffer page is refused at once with a reject pulse, and no bus activity follows.

Top module: `nor_wbuf_prog`

## Requirements
- R1: After reset, ce_n_o, we_n_o and oe_n_o are all high, and busy_o, done_o, tmo_o, rej_o and wnext_o are all low.
- R2: The first two bus writes of an accepted request are data 0x00AA to word address 0x555, then data 0x0055 to word address 0x2AA.
- R3: The third write is data 0x0025 to the sector address. The fourth write is data equal to count minus one to the sector address, so a count of 256 sends 0x00FF.
- R4: The next writes are exactly count address/data pairs. Pair k goes to address start+k. Its data is the fill value in fill mode, or stream word k in stream mode. In stream mode wnext_o pulses once per pair, and in fill mode it never pulses.
- R5: Directly after the last pair, data 0x0029 is written to the sector address. An accepted request makes count+5 writes in total.
- R6: During each write, ce_n_o and we_n_o are low together for exactly WE_LOW clock cycles. fa_o and fd_o do not change while we_n_o is low. oe_n_o stays high at all times.
- R7: If ready (rdy_i high) is low when a request is accepted, no bus write starts until ready has returned high.
- R8: done_o pulses for one cycle only after ready has been seen high following the confirm write. busy_o is low in that cycle.
- R9: If ready stays low for TMO_CYC cycles while the block is waiting on it, tmo_o pulses for one cycle, done_o does not pulse, and the block returns to idle.
- R10: A request with count 0, count greater than WBUF, or (start mod WBUF) + count > WBUF raises rej_o in the cycle after the request. It causes no bus write and leaves busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle program request, sampled while idle |
| sector_i | input | AW | Sector address for command, count and confirm writes |
| start_i | input | AW | Word address of the first buffered word |
| count_i | input | CW | Number of words, 1 to WBUF |
| use_fill_i | input | 1 | 1: every word is fill_i; 0: words come from wdat_i |
| fill_i | input | DW | Fill value |
| wdat_i | input | DW | Current stream word |
| wnext_o | output | 1 | Stream word consumed this cycle |
| rdy_i | input | 1 | Flash ready/busy line, low means busy (asynchronous) |
| fa_o | output | AW | Flash word address |
| fd_o | output | DW | Flash write data |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, held high |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Program finished pulse |
| tmo_o | output | 1 | Ready timeout pulse |
| rej_o | output | 1 | Request refused pulse |

## Verification
The assertions assume that the stream source shows the next word before the next pair is issued. The bench meets this by updating wdat_i on the falling edge after each wnext_o pulse, which always comes several cycles before the next write begins. The assertions also assume that rdy_i moves only between clock edges and that the flash drops it only after a confirm or before a request. The bench's flash model does exactly this. It drives rdy_i on falling edges and pulls it low only after logging the final write, or when a test forces it low before a request.

// File: rtl/nor_wbuf_pkg.sv
package nor_wbuf_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_UNLK1,
    S_UNLK2,
    S_LOAD,
    S_CNT,
    S_PAIRS,
    S_CONF,
    S_GAP,
    S_POLL
  } seq_st_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HOLD
  } strobe_ph_t;

endpackage

// File: rtl/nor_bus_strobe.sv
module nor_bus_strobe
  import nor_wbuf_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int WE_LOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          done_o
);

  localparam int LW = $clog2(WE_LOW + 1);

  strobe_ph_t    ph_q;
  logic [LW-1:0] low_q;
  logic          low_last;

  assign low_last = (low_q == LW'(WE_LOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      low_q  <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go_i) begin
          addr_o <= addr_i;
          data_o <= data_i;
          ph_q   <= PH_SETUP;
        end
        PH_SETUP: begin
          low_q <= '0;
          ph_q  <= PH_LOW;
        end
        PH_LOW: begin
          if (low_last) ph_q <= PH_HOLD;
          else          low_q <= low_q + LW'(1);
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ce_n_o = (ph_q != PH_LOW);
  assign we_n_o = (ph_q != PH_LOW);
  assign done_o = (ph_q == PH_HOLD);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> ($stable(addr_o) && $stable(data_o)));

  // R6
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (ph_q == PH_IDLE));

endmodule

// File: rtl/nor_rdy_watch.sv
module nor_rdy_watch #(
  parameter int TMO_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_a,
  input  logic watch_en,
  output logic rdy_s,
  output logic expired
);

  localparam int TW = $clog2(TMO_CYC + 1);

  logic [1:0]    sync_q;
  logic [TW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], rdy_a};
  end

  assign rdy_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   wait_q <= '0;
    else if (!watch_en)                           wait_q <= '0;
    else if (!rdy_s && (wait_q != TW'(TMO_CYC)))  wait_q <= wait_q + TW'(1);
  end

  assign expired = watch_en && (wait_q == TW'(TMO_CYC));

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= TW'(TMO_CYC));

endmodule

// File: rtl/nor_wbuf_prog.sv
module nor_wbuf_prog
  import nor_wbuf_pkg::*;
#(
  parameter int AW       = 24,
  parameter int DW       = 16,
  parameter int WBUF     = 256,
  parameter int WE_LOW   = 3,
  parameter int BUSY_GAP = 4,
  parameter int TMO_CYC  = 50000,
  parameter logic [AW-1:0] UNLK_A1  = 'h555,
  parameter logic [AW-1:0] UNLK_A2  = 'h2AA,
  parameter logic [DW-1:0] UNLK_D1  = 'hAA,
  parameter logic [DW-1:0] UNLK_D2  = 'h55,
  parameter logic [DW-1:0] CMD_LOAD = 'h25,
  parameter logic [DW-1:0] CMD_CONF = 'h29,
  localparam int PW = $clog2(WBUF),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] sector_i,
  input  logic [AW-1:0] start_i,
  input  logic [CW-1:0] count_i,
  input  logic          use_fill_i,
  input  logic [DW-1:0] fill_i,
  input  logic [DW-1:0] wdat_i,
  output logic          wnext_o,
  input  logic          rdy_i,
  output logic [AW-1:0] fa_o,
  output logic [DW-1:0] fd_o,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          tmo_o,
  output logic          rej_o
);

  localparam int GW = $clog2(BUSY_GAP + 1);

  // A run is legal when it is non-empty, fits the buffer and stays in one page.
  function automatic logic run_fits(input logic [AW-1:0] s, input logic [CW-1:0] n);
    logic [CW:0] end_ofs;
    end_ofs = {2'b00, s[PW-1:0]} + {1'b0, n};
    return (n != '0) && (n <= CW'(WBUF)) && (end_ofs <= (CW+1)'(WBUF));
  endfunction

  function automatic logic [DW-1:0] count_code(input logic [CW-1:0] n);
    return DW'(n - CW'(1));
  endfunction

  seq_st_t       st_q;
  logic [AW-1:0] sec_q, base_q;
  logic [CW-1:0] cnt_q, pidx_q;
  logic          fillm_q;
  logic [DW-1:0] fill_q;
  logic          go_q;
  logic [GW-1:0] gap_q;
  logic          done_q, tmo_q, rej_q;

  // named internal events
  logic          wr_done;
  logic          rdy_s;
  logic          rdy_expired;
  logic          watch_en;
  logic          last_pair;
  logic          req_take;
  logic          req_ok;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  assign req_take  = req_i && (st_q == S_IDLE);
  assign req_ok    = run_fits(start_i, count_i);
  assign watch_en  = (st_q == S_PRE) || (st_q == S_POLL);
  assign last_pair = (pidx_q == cnt_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sec_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      pidx_q  <= '0;
      fillm_q <= 1'b0;
      fill_q  <= '0;
      go_q    <= 1'b0;
      gap_q   <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      rej_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (req_take) begin
          if (req_ok) begin
            sec_q   <= sector_i;
            base_q  <= start_i;
            cnt_q   <= count_i;
            fillm_q <= use_fill_i;
            fill_q  <= fill_i;
            pidx_q  <= '0;
            st_q    <= S_PRE;
          end else begin
            rej_q <= 1'b1;
          end
        end
        S_PRE: begin
          if (rdy_expired) begin
            tmo_q <= 1'b1;
            st_q  <= S_IDLE;
          end else if (rdy_s) begin
            go_q <= 1'b1;
            st_q <= S_UNLK1;
          end
        end
        S_UNLK1: if (wr_done) begin go_q <= 1'b1; st_q <= S_UNLK2; end
        S_UNLK2: if (wr_done) begin go_q <= 1'b1; st_q <= S_LOAD;  end
        S_LOAD:  if (wr_done) begin go_q <= 1'b1; st_q <= S_CNT;   end
        S_CNT:   if (wr_done) begin go_q <= 1'b1; st_q <= S_PAIRS; end
        S_PAIRS: if (wr_done) begin
          go_q <= 1'b1;
          if (last_pair) st_q <= S_CONF;
          else           pidx_q <= pidx_q + CW'(1);
        end
        S_CONF: if (wr_done) begin
          gap_q <= '0;
          st_q  <= S_GAP;
        end
        S_GAP: begin
          if (gap_q == GW'(BUSY_GAP - 1)) st_q <= S_POLL;
          else                            gap_q <= gap_q + GW'(1);
        end
        S_POLL: begin
          if (rdy_expired) begin
            tmo_q <= 1'b1;
            st_q  <= S_IDLE;
          end else if (rdy_s) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr = sec_q;
    bus_data = '0;
    case (st_q)
      S_UNLK1: begin bus_addr = UNLK_A1; bus_data = UNLK_D1; end
      S_UNLK2: begin bus_addr = UNLK_A2; bus_data = UNLK_D2; end
      S_LOAD:  bus_data = CMD_LOAD;
      S_CNT:   bus_data = count_code(cnt_q);
      S_PAIRS: begin
        bus_addr = base_q + AW'(pidx_q);
        bus_data = fillm_q ? fill_q : wdat_i;
      end
      S_CONF:  bus_data = CMD_CONF;
      default: ;
    endcase
  end

  assign wnext_o = go_q && (st_q == S_PAIRS) && !fillm_q;

  nor_bus_strobe #(
    .AW     (AW),
    .DW     (DW),
    .WE_LOW (WE_LOW)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go_q),
    .addr_i (bus_addr),
    .data_i (bus_data),
    .addr_o (fa_o),
    .data_o (fd_o),
    .ce_n_o (ce_n_o),
    .we_n_o (we_n_o),
    .done_o (wr_done)
  );

  nor_rdy_watch #(
    .TMO_CYC (TMO_CYC)
  ) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_a    (rdy_i),
    .watch_en (watch_en),
    .rdy_s    (rdy_s),
    .expired  (rdy_expired)
  );

  assign oe_n_o = 1'b1;
  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
  assign tmo_o  = tmo_q;
  assign rej_o  = rej_q;

  // R7
  start_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && (st_q == S_UNLK1)) |-> $past(rdy_s));

  // R8
  done_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rdy_s) && !busy_o));

  // R9
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> (!done_o && !busy_o));

  // R10
  rej_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_o |-> (ce_n_o && !busy_o));

endmodule

// File: tb/nor_wbuf_prog_bench.sv
module nor_wbuf_prog_bench;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WBUF = 256;
  localparam int CW = 9;
  localparam int WE_LOW = 3;
  localparam int TMO = 300;
  localparam int LOGN = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] sector = '0;
  logic [AW-1:0] start = '0;
  logic [CW-1:0] count = '0;
  logic          use_fill = 1'b0;
  logic [DW-1:0] fill = '0;
  logic [DW-1:0] wdat = '0;
  logic          wnext, rdy;
  logic [AW-1:0] fa;
  logic [DW-1:0] fd;
  logic          ce_n, we_n, oe_n, busy, done, tmo, rej;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nor_wbuf_prog #(
    .AW(AW), .DW(DW), .WBUF(WBUF), .WE_LOW(WE_LOW), .BUSY_GAP(4), .TMO_CYC(TMO)
  ) u_nor_wbuf_prog (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sector_i(sector), .start_i(start),
    .count_i(count), .use_fill_i(use_fill), .fill_i(fill), .wdat_i(wdat),
    .wnext_o(wnext), .rdy_i(rdy), .fa_o(fa), .fd_o(fd), .ce_n_o(ce_n),
    .we_n_o(we_n), .oe_n_o(oe_n), .busy_o(busy), .done_o(done), .tmo_o(tmo),
    .rej_o(rej)
  );

  // flash model and bus logger
  logic [AW-1:0] la [LOGN];
  logic [DW-1:0] ld [LOGN];
  int  nlog = 0, expect_n = 0, low_run = 0, low_bad = 0, ce_bad = 0, oe_bad = 0;
  int  busy_len = 0, busy_left = 0, cyc = 0, rel_cyc = 0;
  bit  stuck = 0, model_busy = 0, force_busy = 0, prev_we = 1;
  int  kstream = 0, nwnext = 0;

  assign rdy = !(model_busy || force_busy);

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(16'hC000 ^ (k * 16'h0107));
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wnext) begin
      kstream <= kstream + 1;
      nwnext  <= nwnext + 1;
    end
  end

  always @(negedge clk) begin
    wdat <= pat(kstream);
    if (rst_n) begin
      if (!oe_n) oe_bad++;
      if (!we_n) begin
        low_run++;
        if (ce_n) ce_bad++;
      end
      if (we_n && !prev_we) begin
        if (nlog < LOGN) begin
          la[nlog] = fa;
          ld[nlog] = fd;
        end
        if (low_run != WE_LOW) low_bad++;
        low_run = 0;
        nlog++;
        if (nlog == expect_n) begin
          model_busy = 1;
          busy_left  = busy_len;
        end
      end else if (model_busy && !stuck) begin
        if (busy_left > 0) busy_left--;
        else begin
          model_busy = 0;
          rel_cyc    = cyc;
        end
      end
      prev_we = we_n;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] s, input logic [AW-1:0] b, input int n,
                       input bit fm, input logic [DW-1:0] fv, input int blen);
    @(negedge clk);
    nlog = 0; low_bad = 0; ce_bad = 0; oe_bad = 0;
    expect_n = n + 5;
    busy_len = blen;
    sector = s; start = b; count = CW'(n); use_fill = fm; fill = fv;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  // returns 1 done, 2 tmo, 3 rej, 0 none
  task automatic wait_end(input int limit, output int how, output int at);
    how = 0; at = 0;
    if (rej) begin how = 3; at = cyc; return; end
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (done) begin how = 1; at = cyc; break; end
      if (tmo)  begin how = 2; at = cyc; break; end
      if (rej)  begin how = 3; at = cyc; break; end
    end
  endtask

  task automatic check_log(input logic [AW-1:0] s, input logic [AW-1:0] b, input int n,
                           input bit fm, input logic [DW-1:0] fv, input int k0);
    int bad_pair = 0, bad_k = -1;
    chk(nlog == n + 5, "R5 write count", nlog, n + 5);
    chk(la[0] == 24'h555 && ld[0] == 16'h00AA, "R2 first unlock", int'(ld[0]), 'hAA);
    chk(la[1] == 24'h2AA && ld[1] == 16'h0055, "R2 second unlock", int'(ld[1]), 'h55);
    chk(la[2] == s && ld[2] == 16'h0025, "R3 load command", int'(ld[2]), 'h25);
    chk(la[3] == s && ld[3] == DW'(n - 1), "R3 count minus one", int'(ld[3]), n - 1);
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] w;
      w = fm ? fv : pat(k0 + k);
      if (la[4+k] != b + AW'(k) || ld[4+k] != w) begin
        bad_pair++;
        if (bad_k < 0) bad_k = k;
      end
    end
    chk(bad_pair == 0, "R4 address/data pairs", bad_k, -1);
    chk(la[n+4] == s && ld[n+4] == 16'h0029, "R5 confirm", int'(ld[n+4]), 'h29);
    chk(low_bad == 0 && ce_bad == 0, "R6 strobe width and CE with WE", low_bad + ce_bad, 0);
    chk(oe_bad == 0, "R6 OE held high", oe_bad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ce_n && we_n && oe_n, "R1 strobes high", {ce_n, we_n, oe_n}, 3'b111);
    chk(!busy && !done && !tmo && !rej && !wnext, "R1 flags low",
        {busy, done, tmo, rej, wnext}, 0);
  endtask

  task automatic t_fill_small;
    int how, at;
    issue(24'h010000, 24'h010000, 4, 1'b1, 16'hA5A5, 20);
    wait_end(2000, how, at);
    chk(how == 1, "R8 done after fill run", how, 1);
    chk(at > rel_cyc && !busy, "R8 done after ready returned", at, rel_cyc + 1);
    check_log(24'h010000, 24'h010000, 4, 1'b1, 16'hA5A5, 0);
  endtask

  task automatic t_stream;
    int how, at, k0, w0;
    k0 = kstream; w0 = nwnext;
    issue(24'h020000, 24'h020010, 16, 1'b0, 16'h0000, 30);
    wait_end(3000, how, at);
    chk(how == 1, "R8 done after stream run", how, 1);
    chk(nwnext - w0 == 16, "R4 wnext pulses per word", nwnext - w0, 16);
    check_log(24'h020000, 24'h020010, 16, 1'b0, 16'h0000, k0);
  endtask

  task automatic t_full;
    int how, at, w0;
    w0 = nwnext;
    issue(24'h030000, 24'h030000, 256, 1'b1, 16'h0000, 10);
    wait_end(5000, how, at);
    chk(how == 1, "R8 done after full buffer", how, 1);
    chk(nwnext == w0, "R4 no wnext in fill mode", nwnext - w0, 0);
    check_log(24'h030000, 24'h030000, 256, 1'b1, 16'h0000, 0);
  endtask

  task automatic t_edge_fit;
    int how, at;
    issue(24'h040000, 24'h040080, 128, 1'b1, 16'h1234, 5);
    wait_end(3000, how, at);
    chk(how == 1, "R10 exact page fit accepted", how, 1);
    check_log(24'h040000, 24'h040080, 128, 1'b1, 16'h1234, 0);
  endtask

  task automatic t_reject(input logic [AW-1:0] b, input int n, input string tag);
    int how, at;
    issue(24'h050000, b, n, 1'b1, 16'hFFFF, 5);
    chk(rej && !busy, {"R10 reject pulse ", tag}, {rej, busy}, 2'b10);
    repeat (20) @(negedge clk);
    chk(nlog == 0 && ce_n, {"R10 no bus write ", tag}, nlog, 0);
  endtask

  task automatic t_prebusy;
    int how, at;
    force_busy = 1;
    repeat (3) @(negedge clk);
    issue(24'h060000, 24'h060000, 2, 1'b1, 16'h5A5A, 5);
    repeat (50) @(negedge clk);
    chk(nlog == 0 && busy, "R7 held off while busy", nlog, 0);
    force_busy = 0;
    wait_end(2000, how, at);
    chk(how == 1, "R7 proceeds after ready", how, 1);
    check_log(24'h060000, 24'h060000, 2, 1'b1, 16'h5A5A, 0);
  endtask

  task automatic t_timeout;
    int how, at;
    stuck = 1;
    issue(24'h070000, 24'h070000, 3, 1'b1, 16'h0F0F, 5);
    wait_end(3000, how, at);
    chk(how == 2, "R9 timeout pulse", how, 2);
    @(negedge clk);
    chk(!busy && !done, "R9 idle after timeout", {busy, done}, 0);
    stuck = 0;
    model_busy = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill_small();
    t_stream();
    t_full();
    t_edge_fit();
    t_reject(24'h050000, 0, "count zero");
    t_reject(24'h050000, 257, "count too big");
    t_reject(24'h050081, 128, "page cross");
    t_prebusy();
    t_timeout();
    t_fill_small();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule